// File: doc/BRIEF.md
# MDIO Management Frame Master

This block issues clause-22 management transactions to an external PHY over a two-wire serial management bus. A client presents one request at a time: read or write, a 5-bit PHY address, a 5-bit register index and, for a write, 16 bits of data. The block serialises the frame on `mdc` and `mdio_o`, and controls `mdio_oe` for an external tristate pad. On reads it turns the line around and samples `mdio_i`. When the frame ends it returns a single-cycle completion that carries the read data and an error flag.

Each frame is 64 bit slots long. In every slot MDC is held low for a half period and then high for a half period. A half period lasts `mdc_div + 1` clock cycles, and `mdc_div` is captured when the request is accepted. Slot k starts at the k-th falling edge of MDC that follows acceptance. Slots 0 to 31 are preamble, 32 to 33 the start code, 34 to 35 the operation, 36 to 40 the PHY address and 41 to 45 the register index. Slots 46 to 63 hold the turnaround and the data.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `req_ready` is 1, `mdc` is 0, `mdio_oe` is 1, `mdio_o` is 1 and `cmp_done` is 0.
- R2: A frame starts in the cycle after acceptance. Every slot has `mdc` low for `mdc_div+1` cycles and then high for `mdc_div+1` cycles, using the divider value captured at acceptance. Slots 0 to 31 carry 1 on `mdio_o`.
- R3: Slots 32 to 45 carry start code 01, then the opcode (read 10, write 01), then the PHY address and then the register index, each field MSB first.
- R4: `mdio_o` changes only at slot boundaries, where MDC falls. It is stable for as long as `mdc` is high.
- R5: For a write, slots 46 and 47 carry the turnaround 1 then 0, and slots 48 to 63 carry the write data MSB first. `mdio_oe` stays 1 for the whole frame.
- R6: For a read, `mdio_oe` drops to 0 at the start of slot 46 while `mdc` is low, and stays 0 up to the end of slot 63.
- R7: For a read, `mdio_i` is sampled in the last low cycle before MDC rises. In slot 47 this sample is the error bit. In slots 48 to 63 these samples are the read data, MSB first.
- R8: If the sampled error bit is 1, the completion carries `cmp_err`=1 and `cmp_rdata`=0.
- R9: `cmp_done` is high for exactly one cycle: the cycle after the last MDC fall of slot 63. In that cycle `mdio_oe` and `mdio_o` are back to 1.
- R10: A request is taken only when `req_ready` is 1. A request or a divider change made while busy has no effect on the frame in progress. A request held high is accepted in the completion cycle itself.
- R11: A write completes with `cmp_err`=0 and `cmp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register index |
| req_wdata | input | 16 | Write data |
| mdc_div | input | DIV_W | Half-period length minus one, in clock cycles |
| cmp_done | output | 1 | One-cycle completion pulse |
| cmp_rdata | output | 16 | Read data (zero on error or write) |
| cmp_err | output | 1 | Read error flag from the turnaround sample |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the data pad |
| mdio_i | input | 1 | Serial data in |

## Verification
Two functions can fall in the same cycle: the completion of one frame and the acceptance of the next. The bench raises a second request while the first frame is still running, changes the divider and the request fields with valid low during the busy period, and then holds valid high. The behavioural model expects the completion pulse, the read result and `req_ready` in one cycle, with the next frame's first low half period starting right after it. Every cycle of both frames, including the new divider value, is compared on each clock.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int SLOT_W    = $clog2(FRAME_LEN);
  localparam int TA_SLOT   = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int ERR_SLOT  = TA_SLOT + 1;
  localparam int DAT_SLOT  = TA_SLOT + 2;

  localparam logic [1:0] CODE_START = 2'b01;
  localparam logic [1:0] CODE_RD    = 2'b10;
  localparam logic [1:0] CODE_WR    = 2'b01;
  localparam logic [1:0] CODE_TA    = 2'b10;

  // whole outgoing bit stream, first slot in the MSB
  function automatic logic [FRAME_LEN-1:0] frame_bits(
    input logic              wr,
    input logic [PHY_W-1:0]  phy,
    input logic [REG_W-1:0]  rg,
    input logic [DATA_W-1:0] wd);
    logic [DATA_W+1:0] tail;
    tail = wr ? {CODE_TA, wd} : {(DATA_W+2){1'b1}};
    return {{PRE_LEN{1'b1}}, CODE_START, (wr ? CODE_WR : CODE_RD), phy, rg, tail};
  endfunction

  // master owns the line in this slot
  function automatic logic master_drives(input logic wr, input logic [SLOT_W-1:0] s);
    return wr || (s < SLOT_W'(TA_SLOT));
  endfunction

  function automatic logic [DATA_W-1:0] read_result(input logic err, input logic [DATA_W-1:0] d);
    return err ? '0 : d;
  endfunction
endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             mdc
);
  logic [DIV_W-1:0] cnt;
  logic             phase;
  logic             half_end;

  assign half_end = run && (cnt == div);
  assign rise_evt = half_end && !phase;
  assign fall_evt = half_end && phase;
  assign mdc      = phase;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (half_end) begin
      cnt   <= '0;
      phase <= !phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take_err,
  input  logic              take_bit,
  input  logic              mdio_i,
  output logic              err_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (take_err) err_q  <= mdio_i;
      if (take_bit) data_q <= {data_q[DATA_W-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DIV_W-1:0]  mdc_div,
  output logic              cmp_done,
  output logic [DATA_W-1:0] cmp_rdata,
  output logic              cmp_err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);

  logic                 busy;
  logic                 is_wr;
  logic [SLOT_W-1:0]    slot;
  logic [FRAME_LEN-1:0] tx_sr;
  logic [DIV_W-1:0]     div_q;
  logic                 accept;
  logic                 rise_evt;
  logic                 fall_evt;
  logic                 last_evt;
  logic                 smp_err;
  logic                 smp_bit;
  logic                 rx_err;
  logic [DATA_W-1:0]    rx_data;
  logic                 done_q;
  logic [DATA_W-1:0]    rdata_q;
  logic                 err_q;

  assign accept   = req_valid && !busy;
  assign last_evt = fall_evt && (slot == LAST_SLOT);
  assign smp_err  = rise_evt && !is_wr && (slot == SLOT_W'(ERR_SLOT));
  assign smp_bit  = rise_evt && !is_wr && (slot >= SLOT_W'(DAT_SLOT));

  mdio_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .div      (div_q),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdc      (mdc)
  );

  mdio_rx_capture u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .take_err (smp_err),
    .take_bit (smp_bit),
    .mdio_i   (mdio_i),
    .err_q    (rx_err),
    .data_q   (rx_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      is_wr <= 1'b0;
      slot  <= '0;
      tx_sr <= '1;
      div_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      is_wr <= req_write;
      slot  <= '0;
      tx_sr <= frame_bits(req_write, req_phy, req_reg, req_wdata);
      div_q <= mdc_div;
    end else if (fall_evt) begin
      slot  <= slot + 1'b1;
      tx_sr <= {tx_sr[FRAME_LEN-2:0], 1'b1};
      if (last_evt) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      done_q <= last_evt;
      if (last_evt) begin
        rdata_q <= is_wr ? '0 : read_result(rx_err, rx_data);
        err_q   <= !is_wr && rx_err;
      end
    end
  end

  assign req_ready = !busy;
  assign cmp_done  = done_q;
  assign cmp_rdata = rdata_q;
  assign cmp_err   = err_q;
  assign mdio_o    = busy ? tx_sr[FRAME_LEN-1] : 1'b1;
  assign mdio_oe   = !busy || master_drives(is_wr, slot);
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cmp_done,
  input logic              cmp_err,
  input logic [DATA_W-1:0] cmp_rdata,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              fall_evt,
  input logic              busy
);
  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mdc && mdio_oe && mdio_o));

  assert_fall_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> $past(fall_evt));

  assert_hold_while_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  assert_release_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> !mdc);

  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_done && cmp_err) |-> (cmp_rdata == '0));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done |=> !cmp_done);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done |-> $past(busy));

  assert_done_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done |-> req_ready);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cmp_done  (cmp_done),
  .cmp_err   (cmp_err),
  .cmp_rdata (cmp_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .fall_evt  (fall_evt),
  .busy      (busy)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  mdc_div = '0;
  logic        cmp_done;
  logic [15:0] cmp_rdata;
  logic        cmp_err;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_master #(.DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .mdc_div(mdc_div), .cmp_done(cmp_done),
    .cmp_rdata(cmp_rdata), .cmp_err(cmp_err), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    logic mdc; logic mdo; logic oe; logic done; logic ready; logic err; logic wr;
    logic [15:0] rdata; int slot;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  logic accepted = 1'b0;
  int phy_falls = 0;
  logic ph_err = 1'b0;
  logic [15:0] ph_data = '0;
  logic cur_err = 1'b0;
  logic [15:0] cur_data = '0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", r, $time, act, expv);
    end
  endtask

  function automatic logic slot_bit(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                                    input logic [15:0] wd, input int s);
    if (s < 32) return 1'b1;
    if (s < 34) return (s == 33);
    if (s < 36) return wr ? (s == 35) : (s == 34);
    if (s < 41) return phy[40-s];
    if (s < 46) return rg[45-s];
    if (s < 48) return (s == 46);
    return wd[63-s];
  endfunction

  task automatic push_frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] wd, input int d, input logic e, input logic [15:0] rd);
    exp_t x;
    for (int s = 0; s < 64; s++) begin
      for (int h = 0; h < 2; h++) begin
        for (int c = 0; c <= d; c++) begin
          x.mdc = (h == 1); x.mdo = slot_bit(wr, phy, rg, wd, s);
          x.oe = wr || (s < 46); x.done = 1'b0; x.ready = 1'b0;
          x.err = 1'b0; x.wr = wr; x.rdata = '0; x.slot = s;
          q.push_back(x);
        end
      end
    end
    x.mdc = 1'b0; x.mdo = 1'b1; x.oe = 1'b1; x.done = 1'b1; x.ready = 1'b1; x.wr = wr;
    x.err = wr ? 1'b0 : e; x.rdata = (wr || e) ? 16'h0 : rd; x.slot = -1;
    q.push_back(x);
  endtask

  // behavioural model: advances at each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      accepted = 1'b0;
    end else begin
      logic ended_idle;
      ended_idle = (q.size() == 0) || q[0].ready;
      if (q.size() != 0) void'(q.pop_front());
      if (ended_idle && req_valid) begin
        push_frame(req_write, req_phy, req_reg, req_wdata, int'(mdc_div), ph_err, ph_data);
        cur_err = ph_err; cur_data = ph_data; phy_falls = 0;
        accepted = 1'b1;
      end else begin
        accepted = 1'b0;
      end
    end
  end

  // PHY responder: changes its output after MDC falls
  always @(negedge mdc) begin
    phy_falls++;
    if (phy_falls == 47) mdio_i = cur_err;
    else if (phy_falls >= 48 && phy_falls <= 63) mdio_i = cur_data[63-phy_falls];
    else mdio_i = 1'b1;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      string mr;
      if (q.size() != 0) e = q[0];
      else begin
        e.mdc = 1'b0; e.mdo = 1'b1; e.oe = 1'b1; e.done = 1'b0; e.ready = 1'b1;
        e.err = 1'b0; e.wr = 1'b0; e.rdata = '0; e.slot = -1;
      end
      chk(mdc === e.mdc, "R2 mdc", 32'(mdc), 32'(e.mdc));
      chk(mdio_oe === e.oe, "R6 mdio_oe", 32'(mdio_oe), 32'(e.oe));
      if (e.oe) begin
        if (e.mdc) mr = "R4 mdio_o held while MDC high";
        else if (e.slot < 0) mr = "R9 mdio_o idle";
        else if (e.slot < 32) mr = "R2 preamble";
        else if (e.slot < 46) mr = "R3 header";
        else mr = "R5 write tail";
        chk(mdio_o === e.mdo, mr, 32'(mdio_o), 32'(e.mdo));
      end
      chk(cmp_done === e.done, "R9 cmp_done", 32'(cmp_done), 32'(e.done));
      chk(req_ready === e.ready, "R10 req_ready", 32'(req_ready), 32'(e.ready));
      if (e.done) begin
        if (e.wr) mr = "R11 write completion";
        else if (e.err) mr = "R8 error completion";
        else mr = "R7 read data";
        chk(cmp_rdata === e.rdata, mr, 32'(cmp_rdata), 32'(e.rdata));
        chk(cmp_err === e.err, mr, 32'(cmp_err), 32'(e.err));
      end
    end
  end

  task automatic set_req(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [7:0] d, input logic e,
                         input logic [15:0] rd);
    req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd; mdc_div = d;
    ph_err = e; ph_data = rd; req_valid = 1'b1;
  endtask

  task automatic wait_accept();
    do begin
      @(posedge clk); #1;
    end while (!accepted);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (R9 completion never seen)");
    report();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(mdc === 1'b0, "R1 mdc", 32'(mdc), 32'd0);
    chk(mdio_oe === 1'b1, "R1 oe", 32'(mdio_oe), 32'd1);
    chk(mdio_o === 1'b1, "R1 mdio_o", 32'(mdio_o), 32'd1);
    chk(cmp_done === 1'b0, "R1 done", 32'(cmp_done), 32'd0);

    // R5/R11: write, fastest divider
    set_req(1'b1, 5'h15, 5'h0A, 16'hA5C3, 8'd0, 1'b0, 16'h0);
    wait_accept(); wait_idle();

    // R7: read, good data
    set_req(1'b0, 5'h01, 5'h02, 16'h0, 8'd1, 1'b0, 16'h1234);
    wait_accept(); wait_idle();

    // R8: read with error bit, data forced to zero
    set_req(1'b0, 5'h0C, 5'h11, 16'h0, 8'd2, 1'b1, 16'hFFFF);
    wait_accept(); wait_idle();

    // R10: busy period ignores changes; second request taken in the done cycle
    set_req(1'b1, 5'h00, 5'h1F, 16'h8001, 8'd0, 1'b0, 16'h0);
    wait_accept();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      req_phy = 5'(i); req_reg = 5'(~i); mdc_div = 8'(i % 4); req_write = i[0];
    end
    @(negedge clk);
    set_req(1'b0, 5'h1F, 5'h1F, 16'h0, 8'd3, 1'b0, 16'h8001);
    wait_accept(); wait_idle();

    // R3: alternating header bits, write, divider 1
    set_req(1'b1, 5'h0A, 5'h15, 16'h5A5A, 8'd1, 1'b0, 16'h0);
    wait_accept(); wait_idle();

    // R7: read of alternating pattern
    set_req(1'b0, 5'h10, 5'h01, 16'h0, 8'd0, 1'b0, 16'hC3A5);
    wait_accept(); wait_idle();

    report();
  end
endmodule